// File: doc/BRIEF.md
# Fractional-N Division Ratio Sequencer

This block feeds the counter chain of a fractional-N synthesizer. Each reference period it supplies the whole-number divide value that the dual-modulus prescaler and its counters use for that period. A second-order error-feedback accumulator runs with a programmable modulus, so the long-run average of the emitted values is the integer part plus the fraction over the modulus. The integer part, the 12-bit fraction, the 12-bit modulus, the prescaler choice and a two-bit noise/spur mode come from static configuration registers. They change only while reset is held.

The divide values leave on a valid/ready stream. The counter chain raises `div_ready` when it takes a value for the next reference period. When `div_valid` is high and `div_ready` is low, `div_val` holds its value and the accumulators do not move. The modulation sequence therefore depends only on how many values have been accepted, not on when they were accepted. The consumer may stall for any length of time. `int_err` is a plain status pin. It reports an integer part below the smallest legal total divide for the chosen prescaler.

Top module: `fnseq_ratio_gen`

## Requirements
- R1: With dither off and `frac_val` nonzero, after the first N accepted values the sum minus N*`int_val` minus floor(N*`frac_val`/`mod_val`) is always 0 or 1. Over `mod_val` values this makes the sum `mod_val`*`int_val`+`frac_val`, to within one.
- R2: `noise_mode` 2'b11 turns on pseudo-random dither, which injects the bit of a 16-bit LFSR into the first accumulator's carry-in. Codes 2'b00, 2'b01 and 2'b10 leave dither off and give identical sequences. Code 2'b11 gives a different sequence.
- R3: With a legal integer part and a nonzero fraction, every emitted value lies in `int_val`-1 through `int_val`+2.
- R4: When `frac_val` is 0 and the integer part is legal, every emitted value equals `int_val` exactly, in every mode including 2'b11.
- R5: When the integer part is illegal, every emitted value equals the floor: 23 when `presc_hi` is 0, or 75 when `presc_hi` is 1.
- R6: `int_err` is 1 exactly when `int_val` is below 23 (when `presc_hi` is 0) or below 75 (when `presc_hi` is 1).
- R7: While `div_valid` is high and `div_ready` is low, `div_val` stays stable. A run with stalls yields the same value sequence as a run without stalls.
- R8: `div_valid` is 0 while `rst_n` is low. It rises on the first clock edge after reset is released and stays high from then on.
- R9: With dither on, over N values the sum stays within 4 + N/`mod_val` of N*(`int_val`+`frac_val`/`mod_val`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears the accumulators, the LFSR and the output stage |
| int_val | input | 16 | Integer part of the divide ratio |
| frac_val | input | 12 | Fraction numerator, below `mod_val` |
| mod_val | input | 12 | Fractional modulus, at least 2 |
| presc_hi | input | 1 | 0 selects the 4/5 prescaler, 1 selects the 8/9 prescaler |
| noise_mode | input | 2 | 2'b11 turns dither on; any other code leaves it off |
| div_valid | output | 1 | A divide value is on offer |
| div_ready | input | 1 | The consumer takes the value offered this cycle |
| div_val | output | 17 | Divide value for one reference period |
| int_err | output | 1 | Integer part below the prescaler's minimum |

## Verification
The assertions assume that the configuration inputs hold still whenever reset is released, that `frac_val` is below `mod_val`, and that `mod_val` is at least 2. Each directed scenario programs its configuration while reset is held, keeps the fraction below the modulus, and keeps the modulus at 2 or more. Under those conditions the properties can compare `div_val` directly with the current `int_val` and `frac_val` ports. Back-pressure is applied only through `div_ready`. Its pattern is pseudo-random in the stall scenario and always asserted elsewhere.

// File: rtl/fnseq_pkg.sv
package fnseq_pkg;
  typedef enum logic [1:0] {
    NM_QUIET  = 2'b00,
    NM_MIXED  = 2'b01,
    NM_SPARE  = 2'b10,
    NM_SMOOTH = 2'b11
  } noise_mode_e;

  function automatic logic dither_enabled(input logic [1:0] mode);
    return noise_mode_e'(mode) == NM_SMOOTH;
  endfunction
endpackage

// File: rtl/fnseq_lfsr.sv
module fnseq_lfsr #(
  parameter int W = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic bit_o
);
  logic [W-1:0] state;

  always_ff @(posedge clk) begin
    if (!rst_n)
      state <= SEED;
    else if (step)
      state <= state[0] ? ((state >> 1) ^ TAPS) : (state >> 1);
  end

  assign bit_o = state[0];
endmodule

// File: rtl/fnseq_accum.sv
module fnseq_accum #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] modulus,
  input  logic [W-1:0] addend,
  input  logic         cin,
  output logic [W-1:0] acc_next,
  output logic         carry
);
  localparam int SW = W + 1;

  logic [W-1:0]  acc;
  logic [SW-1:0] sum;

  always_comb begin
    sum      = {1'b0, acc} + {1'b0, addend} + SW'(cin);
    carry    = (sum >= {1'b0, modulus});
    acc_next = carry ? W'(sum - {1'b0, modulus}) : sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      acc <= '0;
    else if (step)
      acc <= acc_next;
  end
endmodule

// File: rtl/fnseq_floor.sv
module fnseq_floor #(
  parameter int INT_W   = 16,
  parameter int OUT_W   = INT_W + 1,
  parameter int NMIN_LO = 23,
  parameter int NMIN_HI = 75
) (
  input  logic [INT_W-1:0] int_val,
  input  logic             presc_hi,
  output logic             int_err,
  output logic [OUT_W-1:0] floor_val
);
  localparam logic [INT_W-1:0] MIN_LO = INT_W'(NMIN_LO);
  localparam logic [INT_W-1:0] MIN_HI = INT_W'(NMIN_HI);

  logic [INT_W-1:0] limit;

  always_comb begin
    limit     = presc_hi ? MIN_HI : MIN_LO;
    int_err   = (int_val < limit);
    floor_val = {{(OUT_W-INT_W){1'b0}}, limit};
  end
endmodule

// File: rtl/fnseq_ratio_gen.sv
module fnseq_ratio_gen #(
  parameter int INT_W     = 16,
  parameter int FRAC_W    = 12,
  parameter int NMIN_LO   = 23,
  parameter int NMIN_HI   = 75,
  parameter int LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  localparam int OUT_W    = INT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  int_val,
  input  logic [FRAC_W-1:0] frac_val,
  input  logic [FRAC_W-1:0] mod_val,
  input  logic              presc_hi,
  input  logic [1:0]        noise_mode,
  output logic              div_valid,
  input  logic              div_ready,
  output logic [OUT_W-1:0]  div_val,
  output logic              int_err
);
  import fnseq_pkg::*;

  localparam int STAGES = 2;

  logic              load;
  logic              step;
  logic              frac_zero;
  logic              dither_bit;
  logic              dither;
  logic              c2_prev;
  logic [OUT_W-1:0]  floor_val;
  logic [OUT_W-1:0]  modulated;
  logic [OUT_W-1:0]  next_div;

  logic [FRAC_W-1:0] addend   [STAGES];
  logic [FRAC_W-1:0] acc_next [STAGES];
  logic [STAGES-1:0] cin;
  logic [STAGES-1:0] carry;

  assign load      = !div_valid || div_ready;
  assign frac_zero = (frac_val == '0);
  assign step      = load && !frac_zero;
  assign dither    = dither_enabled(noise_mode) && dither_bit;

  fnseq_lfsr #(
    .W   (LFSR_W),
    .TAPS(LFSR_TAPS),
    .SEED(LFSR_SEED)
  ) u_lfsr (
    .clk  (clk),
    .rst_n(rst_n),
    .step (step),
    .bit_o(dither_bit)
  );

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign addend[g] = frac_val;
      assign cin[g]    = dither;
    end else begin : g_chain
      assign addend[g] = acc_next[g-1];
      assign cin[g]    = 1'b0;
    end

    fnseq_accum #(.W(FRAC_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step),
      .modulus (mod_val),
      .addend  (addend[g]),
      .cin     (cin[g]),
      .acc_next(acc_next[g]),
      .carry   (carry[g])
    );
  end

  fnseq_floor #(
    .INT_W  (INT_W),
    .OUT_W  (OUT_W),
    .NMIN_LO(NMIN_LO),
    .NMIN_HI(NMIN_HI)
  ) u_floor (
    .int_val  (int_val),
    .presc_hi (presc_hi),
    .int_err  (int_err),
    .floor_val(floor_val)
  );

  // Second-order noise shaping: first carry plus first difference of the second.
  always_comb begin
    modulated = {1'b0, int_val} + OUT_W'(carry[0]) + OUT_W'(carry[1]) - OUT_W'(c2_prev);
    if (int_err)
      next_div = floor_val;
    else if (frac_zero)
      next_div = {1'b0, int_val};
    else
      next_div = modulated;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c2_prev   <= 1'b0;
      div_valid <= 1'b0;
      div_val   <= '0;
    end else if (load) begin
      div_valid <= 1'b1;
      div_val   <= next_div;
      if (step)
        c2_prev <= carry[1];
    end
  end
endmodule

// File: rtl/fnseq_checker.sv
module fnseq_checker #(
  parameter int INT_W   = 16,
  parameter int FRAC_W  = 12,
  parameter int NMIN_LO = 23,
  parameter int NMIN_HI = 75,
  parameter int OUT_W   = INT_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [INT_W-1:0]  int_val,
  input logic [FRAC_W-1:0] frac_val,
  input logic              presc_hi,
  input logic              div_valid,
  input logic              div_ready,
  input logic [OUT_W-1:0]  div_val,
  input logic              int_err
);
  localparam int XW = OUT_W + 1;

  logic [XW-1:0] x_div;
  logic [XW-1:0] x_int;
  logic [XW-1:0] x_min;

  assign x_div = {1'b0, div_val};
  assign x_int = XW'(int_val);
  assign x_min = presc_hi ? XW'(NMIN_HI) : XW'(NMIN_LO);

  assert_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (div_valid && !int_err && frac_val != '0) |->
      (x_div + 1 >= x_int && x_div <= x_int + 2));

  assert_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (div_valid && !int_err && frac_val == '0) |-> (x_div == x_int));

  assert_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (div_valid && int_err) |-> (x_div == x_min));

  assert_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int_err == (x_int < x_min));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (div_valid && !div_ready) |=> (div_valid && $stable(div_val)));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    div_valid |=> div_valid);
endmodule

bind fnseq_ratio_gen fnseq_checker #(
  .INT_W  (INT_W),
  .FRAC_W (FRAC_W),
  .NMIN_LO(NMIN_LO),
  .NMIN_HI(NMIN_HI),
  .OUT_W  (OUT_W)
) u_fnseq_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .int_val  (int_val),
  .frac_val (frac_val),
  .presc_hi (presc_hi),
  .div_valid(div_valid),
  .div_ready(div_ready),
  .div_val  (div_val),
  .int_err  (int_err)
);

// File: tb/tb_fnseq_ratio_gen.sv
module tb_fnseq_ratio_gen;
  localparam int INT_W  = 16;
  localparam int FRAC_W = 12;
  localparam int OUT_W  = INT_W + 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [INT_W-1:0]  int_val = '0;
  logic [FRAC_W-1:0] frac_val = '0;
  logic [FRAC_W-1:0] mod_val = 12'd2;
  logic              presc_hi = 1'b0;
  logic [1:0]        noise_mode = 2'b00;
  logic              div_valid;
  logic              div_ready = 1'b0;
  logic [OUT_W-1:0]  div_val;
  logic              int_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  int got [0:4095];
  int ref_seq [0:4095];

  always #4 clk = ~clk;

  fnseq_ratio_gen dut (
    .clk(clk), .rst_n(rst_n), .int_val(int_val), .frac_val(frac_val),
    .mod_val(mod_val), .presc_hi(presc_hi), .noise_mode(noise_mode),
    .div_valid(div_valid), .div_ready(div_ready), .div_val(div_val),
    .int_err(int_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic start(input int iv, input int fv, input int mv,
                       input bit ph, input logic [1:0] md);
    @(negedge clk);
    rst_n = 1'b0;
    div_ready = 1'b0;
    int_val = INT_W'(iv);
    frac_val = FRAC_W'(fv);
    mod_val = FRAC_W'(mv);
    presc_hi = ph;
    noise_mode = md;
    repeat (3) @(negedge clk);
    chk(div_valid == 1'b0, "R8", "valid during reset", div_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(div_valid == 1'b1, "R8", "valid after reset", div_valid, 1);
  endtask

  task automatic collect(input int n, input bit stall);
    int k;
    bit have_held;
    logic [OUT_W-1:0] held;
    k = 0;
    have_held = 0;
    held = '0;
    while (k < n) begin
      if (have_held) begin
        chk(div_val == held, "R7", "held value under stall", div_val, held);
        have_held = 0;
      end
      div_ready = stall ? ($urandom_range(0, 2) != 0) : 1'b1;
      if (div_valid && div_ready) begin
        got[k] = int'(div_val);
        k++;
      end else if (div_valid) begin
        held = div_val;
        have_held = 1;
      end
      @(negedge clk);
    end
    div_ready = 1'b0;
  endtask

  task automatic t_reset;
    start(100, 5, 9, 1'b1, 2'b00);
    chk(int_err == 1'b0, "R6", "no error for legal INT", int_err, 0);
  endtask

  task automatic t_frac_zero;
    start(200, 0, 100, 1'b1, 2'b11);
    collect(40, 1'b0);
    for (int i = 0; i < 40; i++)
      chk(got[i] == 200, "R4", "zero fraction exact", got[i], 200);
  endtask

  task automatic t_average(input int iv, input int fv, input int mv,
                           input bit ph, input logic [1:0] md);
    longint cum;
    longint excess;
    start(iv, fv, mv, ph, md);
    collect(mv, 1'b0);
    cum = 0;
    for (int i = 0; i < mv; i++) begin
      chk(got[i] >= iv - 1 && got[i] <= iv + 2, "R3", "value in range", got[i], iv);
      cum += got[i];
      excess = cum - longint'(i + 1) * iv - (longint'(i + 1) * fv) / mv;
      chk(excess == 0 || excess == 1, "R1", "cumulative excess", excess, 0);
    end
    excess = cum - longint'(mv) * iv - fv;
    chk(excess == 0 || excess == 1, "R1", "sum over MOD ticks", cum, longint'(mv) * iv + fv);
  endtask

  task automatic t_modes;
    int diffs;
    real dev;
    real bound;
    longint cum;
    start(150, 333, 1000, 1'b1, 2'b00);
    collect(2000, 1'b0);
    for (int i = 0; i < 2000; i++) ref_seq[i] = got[i];
    start(150, 333, 1000, 1'b1, 2'b01);
    collect(2000, 1'b0);
    diffs = 0;
    for (int i = 0; i < 2000; i++) if (got[i] != ref_seq[i]) diffs++;
    chk(diffs == 0, "R2", "mode 01 matches mode 00", diffs, 0);
    start(150, 333, 1000, 1'b1, 2'b10);
    collect(2000, 1'b0);
    diffs = 0;
    for (int i = 0; i < 2000; i++) if (got[i] != ref_seq[i]) diffs++;
    chk(diffs == 0, "R2", "mode 10 matches mode 00", diffs, 0);
    start(150, 333, 1000, 1'b1, 2'b11);
    collect(2000, 1'b0);
    diffs = 0;
    cum = 0;
    for (int i = 0; i < 2000; i++) begin
      if (got[i] != ref_seq[i]) diffs++;
      cum += got[i];
      chk(got[i] >= 149 && got[i] <= 152, "R3", "dithered value in range", got[i], 150);
    end
    chk(diffs > 0, "R2", "mode 11 differs from mode 00", diffs, 1);
    dev = real'(cum) - 2000.0 * (150.0 + 333.0 / 1000.0);
    if (dev < 0.0) dev = -dev;
    bound = 4.0 + 2000.0 / 1000.0;
    chk(dev <= bound, "R9", "dithered mean deviation", longint'(dev), longint'(bound));
  endtask

  task automatic t_floor(input int iv, input bit ph, input bit exp_err, input int exp_val);
    start(iv, 17, 40, ph, 2'b00);
    chk(int_err == exp_err, "R6", "error flag", int_err, exp_err);
    collect(4, 1'b0);
    for (int i = 0; i < 4; i++)
      if (exp_err) chk(got[i] == exp_val, "R5", "floor value", got[i], exp_val);
      else chk(got[i] >= exp_val - 1 && got[i] <= exp_val + 2, "R3", "legal boundary range", got[i], exp_val);
  endtask

  task automatic t_stall;
    int diffs;
    start(300, 777, 1001, 1'b1, 2'b11);
    collect(300, 1'b0);
    for (int i = 0; i < 300; i++) ref_seq[i] = got[i];
    start(300, 777, 1001, 1'b1, 2'b11);
    collect(300, 1'b1);
    diffs = 0;
    for (int i = 0; i < 300; i++) if (got[i] != ref_seq[i]) diffs++;
    chk(diffs == 0, "R7", "stalled sequence equals free-running", diffs, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_frac_zero();
    t_average(100, 1234, 4095, 1'b1, 2'b00);
    t_average(23, 3, 7, 1'b0, 2'b01);
    t_average(500, 4094, 4095, 1'b1, 2'b00);
    t_average(80, 1, 2, 1'b1, 2'b10);
    t_modes();
    t_floor(10, 1'b0, 1'b1, 23);
    t_floor(22, 1'b0, 1'b1, 23);
    t_floor(23, 1'b0, 1'b0, 23);
    t_floor(50, 1'b1, 1'b1, 75);
    t_floor(74, 1'b1, 1'b1, 75);
    t_floor(75, 1'b1, 1'b0, 75);
    t_stall();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule